// File: doc/BRIEF.md
# Fractional Sample-Clock Divider

This block derives a sample clock whose average rate is a programmable rational fraction of a reference clock. Two 12-bit values, a numerator `lCount` and an offset `mCount`, set the ratio: output frequency over reference frequency equals L / (4096 − M + L). The block has no single fixed divisor. It moves a phase accumulator of modulus D = 4096 − M + L forward by L on every reference cycle. Each time the accumulator wraps, a new output period begins, so the output periods are a mix of the two integer lengths that lie on either side of D / L. An average ratio of 4.5, for example, comes out as an even mix of 4-cycle and 5-cycle periods.

A select input picks either the divided clock or the raw reference for the clock output. The select takes effect only when both candidates are low, so the output never carries a runt pulse. Next to the clock, a one-cycle strobe marks the first reference cycle of every output period. Logic on the reference domain can use this strobe as a sample enable.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is held, the active ratio is L = 256, M = 1563 (D = 2789), `tick` is low and `clkOut` follows `clk`. The divided path is not selected until a falling edge of `clk` after reset is released.
- R2: With a steady nonzero L, any D consecutive reference cycles hold exactly L cycles with `tick` high.
- R3: The number of reference cycles between successive `tick` pulses is always floor(D/L) or ceil(D/L).
- R4: Let the phase be (k·L) mod D, where k counts reference cycles since the active ratio was last loaded. `tick` is high in each cycle where a new output period starts. The divided clock is high in exactly the cycles whose phase is below floor(D/2).
- R5: When the active L is 0, the divider is stopped: `tick` stays low and, with the divided path selected, `clkOut` stays low.
- R6: With `fracEn` = 0, `clkOut` equals `clk` in both clock phases. `tick` keeps marking divided periods.
- R7: New `lCount` or `mCount` values are taken only in a cycle where a period wraps. If they differ from the active pair, the phase restarts at 0. Otherwise the accumulator keeps running.
- R8: While stopped, a nonzero `lCount` is loaded at the next rising edge. `tick` is high in the cycle that follows that edge.
- R9: The path select changes only at a falling edge of `clk` at which the divided clock is low. It then takes the value of `fracEn` ANDed with "active L nonzero".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fracEn | input | 1 | 1 selects the divided clock, 0 passes the reference through |
| lCount | input | 12 | Accumulator step L |
| mCount | input | 12 | Modulus offset M, D = 4096 − M + L |
| clkOut | output | 1 | Selected output clock |
| tick | output | 1 | One-cycle strobe at the start of each output period |

## Verification
`tick` and the divided-clock level are registered. Each one is due in the reference cycle that follows the rising edge at which the accumulator moves. The path select is due at the falling edge that follows. The reference model steps at every rising edge and applies the select rule at every falling edge. It compares `tick` and `clkOut` a quarter period after each edge. Inputs change 2 ns after a rising edge, so no sample lands on a moving signal. Ratio counts and interval bounds are collected over windows of whole multiples of D. A new pair of values is given time to load before each window opens.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

  // Strobes from control to datapath for one reference cycle
  typedef struct packed {
    logic restart;   // phase back to zero (load or stopped)
    logic wrapAdv;   // advance and subtract the modulus
    logic plainAdv;  // advance without wrap
    logic run;       // divider runs after this edge
  } divCmd_t;

endpackage

// File: rtl/fracdiv_ctrl.sv
module fracdiv_ctrl
  import fracdiv_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int RST_L = 256,
  parameter int RST_M = 1563,
  localparam int ACC_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] lIn,
  input  logic [CNT_W-1:0] mIn,
  input  logic             sumHits,
  output divCmd_t          cmd,
  output logic [ACC_W-1:0] halfNext,
  output logic [CNT_W-1:0] actL,
  output logic [ACC_W-1:0] actD,
  output logic             running,
  output logic             tick
);

  localparam logic [ACC_W-1:0] MOD_BASE = ACC_W'(1) << CNT_W;
  localparam logic [ACC_W-1:0] RST_D    = MOD_BASE - ACC_W'(RST_M) + ACC_W'(RST_L);

  logic [ACC_W-1:0] reqD;
  logic [ACC_W-1:0] nextD;
  logic [CNT_W-1:0] nextL;
  logic             wrap;
  logic             change;
  logic             doLoad;

  always_comb begin
    reqD     = MOD_BASE - ACC_W'(mIn) + ACC_W'(lIn);
    running  = (actL != '0);
    wrap     = running && sumHits;
    change   = (lIn != actL) || (reqD != actD);
    doLoad   = (wrap || !running) && change;
    nextL    = doLoad ? lIn  : actL;
    nextD    = doLoad ? reqD : actD;
    halfNext = nextD >> 1;
    cmd.restart  = doLoad || !running;
    cmd.wrapAdv  = !doLoad && wrap;
    cmd.plainAdv = !doLoad && running && !sumHits;
    cmd.run      = (nextL != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actL <= CNT_W'(RST_L);
      actD <= RST_D;
      tick <= 1'b0;
    end else begin
      actL <= nextL;
      actD <= nextD;
      tick <= wrap || (!running && (lIn != '0));
    end
  end

  // R5: stopped with zero request never strobes
  assert_stop_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (actL == '0 && lIn == '0) |=> !tick);

  // R7: the active step only changes on a period start
  assert_load_on_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actL) |-> tick);

endmodule

// File: rtl/fracdiv_dp.sv
module fracdiv_dp
  import fracdiv_pkg::*;
#(
  parameter int   CNT_W  = 12,
  parameter logic RST_HI = 1'b1,
  localparam int  ACC_W  = CNT_W + 1,
  localparam int  SUM_W  = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] actL,
  input  logic [ACC_W-1:0] actD,
  input  divCmd_t          cmd,
  input  logic [ACC_W-1:0] halfNext,
  output logic             sumHits,
  output logic             divHi
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] diff;

  always_comb begin
    sum     = SUM_W'(acc) + SUM_W'(actL);
    diff    = sum - SUM_W'(actD);
    sumHits = (sum >= SUM_W'(actD));
    if (cmd.restart)       accNext = '0;
    else if (cmd.wrapAdv)  accNext = diff[ACC_W-1:0];
    else if (cmd.plainAdv) accNext = sum[ACC_W-1:0];
    else                   accNext = acc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      divHi <= RST_HI;
    end else begin
      acc   <= accNext;
      divHi <= cmd.run && (accNext < halfNext);
    end
  end

  // R2: phase stays inside the modulus while running
  assert_acc_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (actL != '0) |-> (acc < actD));

endmodule

// File: rtl/fracdiv_clksel.sv
module fracdiv_clksel (
  input  logic clk,
  input  logic rstN,
  input  logic fracEn,
  input  logic running,
  input  logic divHi,
  output logic clkOut
);

  logic selDiv;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)      selDiv <= 1'b0;
    else if (!divHi) selDiv <= fracEn && running;
  end

  assign clkOut = selDiv ? divHi : clk;

  // R9: select moves only while the divided clock was low
  assert_glitch_free_R9: assert property (@(negedge clk) disable iff (!rstN)
    !$stable(selDiv) |-> !$past(divHi));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fracdiv_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int RST_L = 256,
  parameter int RST_M = 1563
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fracEn,
  input  logic [CNT_W-1:0] lCount,
  input  logic [CNT_W-1:0] mCount,
  output logic             clkOut,
  output logic             tick
);

  localparam int   ACC_W  = CNT_W + 1;
  localparam logic RST_HI = (RST_L != 0);

  divCmd_t          cmd;
  logic [ACC_W-1:0] halfNext;
  logic [CNT_W-1:0] actL;
  logic [ACC_W-1:0] actD;
  logic             running;
  logic             sumHits;
  logic             divHi;

  fracdiv_ctrl #(.CNT_W(CNT_W), .RST_L(RST_L), .RST_M(RST_M)) uCtrl (
    .clk(clk), .rstN(rstN), .lIn(lCount), .mIn(mCount), .sumHits(sumHits),
    .cmd(cmd), .halfNext(halfNext), .actL(actL), .actD(actD),
    .running(running), .tick(tick)
  );

  fracdiv_dp #(.CNT_W(CNT_W), .RST_HI(RST_HI)) uDp (
    .clk(clk), .rstN(rstN), .actL(actL), .actD(actD), .cmd(cmd),
    .halfNext(halfNext), .sumHits(sumHits), .divHi(divHi)
  );

  fracdiv_clksel uSel (
    .clk(clk), .rstN(rstN), .fracEn(fracEn), .running(running),
    .divHi(divHi), .clkOut(clkOut)
  );

endmodule

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fracEn;
  logic [11:0] lCount;
  logic [11:0] mCount;
  logic        clkOut;
  logic        tick;

  always #10 clk = ~clk;

  frac_clk_div uut (
    .clk(clk), .rstN(rstN), .fracEn(fracEn), .lCount(lCount),
    .mCount(mCount), .clkOut(clkOut), .tick(tick)
  );

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  longint mL = 256, mD = 2789, mk = 0;
  bit     eTick = 1'b0, eHi = 1'b1, eSel = 1'b0;

  // window statistics
  bit measure = 1'b0;
  int cyc = 0, tickCnt = 0, lastT = -1, minIv = 1 << 30, maxIv = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mL = 256; mD = 2789; mk = 0; eTick = 0; eHi = 1;
    end else begin
      longint reqD;
      bit run, wrap, chg;
      reqD  = 4096 - longint'(mCount) + longint'(lCount);
      run   = (mL != 0);
      wrap  = run && (((mk + 1) * mL) / mD != (mk * mL) / mD);
      chg   = (longint'(lCount) != mL) || (reqD != mD);
      eTick = wrap || (!run && lCount != 0);
      if ((wrap || !run) && chg) begin
        mL = longint'(lCount); mD = reqD; mk = 0;
      end else if (run) mk++;
      else mk = 0;
      eHi = (mL != 0) && (((mk * mL) % mD) < mD / 2);
    end
    #5;
    check(tick == eTick, tag, "tick", tick, eTick);
    check(clkOut == (eSel ? eHi : 1'b1), tag, "clkOut high phase", clkOut, eSel ? eHi : 1'b1);
    cyc++;
    if (measure && tick) begin
      tickCnt++;
      if (lastT >= 0) begin
        if (cyc - lastT < minIv) minIv = cyc - lastT;
        if (cyc - lastT > maxIv) maxIv = cyc - lastT;
      end
      lastT = cyc;
    end
  end

  always @(negedge clk) begin
    if (!rstN) eSel = 0;
    else if (!eHi) eSel = fracEn && (mL != 0);
    #5;
    check(clkOut == (eSel ? eHi : 1'b0), tag, "clkOut low phase", clkOut, eSel ? eHi : 1'b0);
  end

  task automatic setCfg(input int l, input int m);
    @(posedge clk); #2;
    lCount = 12'(l); mCount = 12'(m);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // R2 count and R3 interval bounds over n windows of D cycles
  task automatic window(input int l, input int d, input int n);
    tickCnt = 0; lastT = -1; minIv = 1 << 30; maxIv = 0; measure = 1;
    repeat (n * d) @(posedge clk);
    #2; measure = 0;
    check(tickCnt == n * l, "R2", "ticks in window", tickCnt, n * l);
    check(minIv == d / l, "R3", "shortest period", minIv, d / l);
    check(maxIv == (d + l - 1) / l, "R3", "longest period", maxIv, (d + l - 1) / l);
  endtask

  initial begin
    rstN = 0; fracEn = 0; lCount = 12'd256; mCount = 12'd1563;
    repeat (3) @(posedge clk);
    #2; rstN = 1; fracEn = 1; tag = "R4";
    idle(3000);
    tag = "R7";
    setCfg(2, 4093);          // D = 5, taken at next wrap
    idle(40);
    window(2, 5, 20);
    setCfg(2, 4089);          // D = 9, ratio 4.5
    idle(40);
    tag = "R4";
    window(2, 9, 10);
    setCfg(1, 4095);          // D = 2, boundary
    idle(20);
    window(1, 2, 50);
    setCfg(4095, 4095);       // D = 4096, ratio just below one
    idle(20);
    window(4095, 4096, 1);
    tag = "R6";
    @(posedge clk); #2; fracEn = 0;
    idle(60);
    @(posedge clk); #2; fracEn = 1;
    tag = "R5";
    setCfg(0, 4093);
    idle(40);
    tickCnt = 0; measure = 1;
    idle(50);
    measure = 0;
    check(tickCnt == 0, "R5", "ticks while stopped", tickCnt, 0);
    tag = "R8";
    setCfg(3, 4092);          // D = 7 from stopped
    @(posedge clk); #4;
    check(tick == 1'b1, "R8", "tick after restart", tick, 1);
    idle(10);
    window(3, 7, 10);
    tag = "R9";
    for (int i = 0; i < 14; i++) begin
      repeat (3 + (i % 5)) @(posedge clk);
      #2; fracEn = ~fracEn;
    end
    idle(20);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule